// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a 36-bit synchronous static RAM. The word is split into four 9-bit byte lanes that are written under separate masks. Every rising clock edge can carry a new command. A command is either a load of a fresh address with a read/write direction, an advance of the burst in progress, or a deselect. The data for a command moves on the shared bidirectional bus during the following clock period. Reads and writes can therefore alternate on every edge with no idle cycle between them.

A burst covers four words within an aligned group of four. The two low address bits step in one of two orders, chosen by a static mode pin. A clock-enable input that is high freezes the whole pipeline, as if the edge never happened. An asynchronous output enable gates the read drivers. The memory depth is set by the address-width parameter. Its default is small so that simulation stays light.

Top module: `zt_sram`

## Requirements
- R1: On a rising edge with `ce_n` low, `adv_ld_n` low and the part selected, the block captures `addr` and the direction (`we_n` low means write) as a new command.
- R2: The part is selected only when `cs_a_n` and `cs_b_n` are low and `cs_c` is high. Any other combination with `adv_ld_n` low is a deselect. An advance that follows a deselect keeps the part idle.
- R3: After reset, and from the clock period that follows a deselect edge, the block does not drive `dq`.
- R4: For a read command captured at edge N, the stored word is driven on `dq` during the period between edge N and edge N+1.
- R5: Write data on `dq` and the active-low masks `bw_n` are sampled at the enabled edge that follows the command. `bw_n[i]` low writes bits `9*i+8 : 9*i`, and bytes whose mask is high keep their old contents.
- R6: During a read, `bw_n` has no effect on the memory.
- R7: At an edge with `ce_n` high, every other input is ignored and the outputs and the pending operation are unchanged. A pending write is committed at the next enabled edge, with the data present at that edge.
- R8: At an enabled edge with `adv_ld_n` high, `addr` and `we_n` are ignored and the active burst steps to its next word in the same direction. With `lin_burst` = 1 the low two address bits follow base+k mod 4. With `lin_burst` = 0 they follow base XOR k, for k = 0..3.
- R9: The read drivers are on only while `oe_n` is low. When `oe_n` is high, `dq` floats at once.
- R10: A read, a write and a read on three consecutive edges complete with no idle cycle. During the write's data period the block does not drive against the external write data, and the read that follows sees the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset to the idle, deselected state |
| addr | input | ADDR_W | Word address for load commands |
| cs_a_n | input | 1 | Active-low chip select A |
| cs_b_n | input | 1 | Active-low chip select B |
| cs_c | input | 1 | Active-high chip select C |
| adv_ld_n | input | 1 | Low: load or deselect. High: advance the burst |
| we_n | input | 1 | Direction of a loaded command: low means write |
| ce_n | input | 1 | Active-low clock enable. High freezes the block |
| bw_n | input | 4 | Active-low byte write masks, one per 9-bit lane |
| lin_burst | input | 1 | Static burst order: 1 is linear, 0 is interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable for reads |
| dq | inout | 36 | Bidirectional data bus |

## Verification
On one edge the block can commit the previous command's write and also capture a new read of the same word. The bench provokes this by issuing a write and then a read of that address on the next edge. The read must return the new word in the following period. The same edge also hands the bus from external write data to the block's own drivers. The bench samples `dq` in the write's data period and expects exactly the value it drives there, so any contention shows up as an X mismatch. The bench also places a frozen edge between a write command and its data, and requires that the data present at the later enabled edge is the data stored.

// File: rtl/zt_pkg.sv
package zt_pkg;

    typedef enum logic [1:0] {
        CMD_DESEL = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_ADV   = 2'd2
    } zt_cmd_e;

    // low two address bits of burst beat k from base b
    function automatic logic [1:0] burst_low(input logic [1:0] b,
                                             input logic [1:0] k,
                                             input logic       lin);
        return lin ? (b + k) : (b ^ k);
    endfunction

endpackage

// File: rtl/zt_cmd_decode.sv
module zt_cmd_decode
    import zt_pkg::*;
(
    input  logic    cs_a_n,
    input  logic    cs_b_n,
    input  logic    cs_c,
    input  logic    adv_ld_n,
    output zt_cmd_e cmd
);
    logic sel;

    always_comb begin
        sel = !cs_a_n && !cs_b_n && cs_c;
        if (adv_ld_n)
            cmd = CMD_ADV;
        else if (sel)
            cmd = CMD_LOAD;
        else
            cmd = CMD_DESEL;
    end
endmodule

// File: rtl/zt_burst_seq.sv
module zt_burst_seq
    import zt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  zt_cmd_e           cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we_n,
    input  logic              lin_burst,
    output logic              act_o,
    output logic              wr_o,
    output logic [ADDR_W-1:0] eff_addr
);
    typedef struct packed {
        logic              act;
        logic              wr;
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (en) begin
            case (cmd)
                CMD_LOAD: begin
                    s_d.act  = 1'b1;
                    s_d.wr   = !we_n;
                    s_d.base = addr;
                    s_d.cnt  = 2'd0;
                end
                CMD_DESEL: s_d.act = 1'b0;
                CMD_ADV: if (s_q.act) s_d.cnt = s_q.cnt + 2'd1;
                default: s_d = s_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act_o    = s_q.act;
    assign wr_o     = s_q.wr;
    assign eff_addr = {s_q.base[ADDR_W-1:2], burst_low(s_q.base[1:0], s_q.cnt, lin_burst)};

    assert_load_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cmd == CMD_LOAD) |=> (act_o && (wr_o == !$past(we_n)) && s_q.cnt == 2'd0));

    assert_deselect_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cmd == CMD_DESEL) |=> !act_o);

    assert_burst_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cmd == CMD_ADV && act_o) |=>
            (act_o && wr_o == $past(wr_o) && s_q.cnt == $past(s_q.cnt) + 2'd1));
endmodule

// File: rtl/zt_byte_mem.sv
module zt_byte_mem #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic [LANES-1:0]         wmask_n,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [LANES*LANE_W-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int DW    = LANES * LANE_W;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int g = 0; g < LANES; g++) begin
                if (!wmask_n[g]) mem[waddr][g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    cs_a_n,
    input  logic                    cs_b_n,
    input  logic                    cs_c,
    input  logic                    adv_ld_n,
    input  logic                    we_n,
    input  logic                    ce_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    lin_burst,
    input  logic                    oe_n,
    inout  wire  [LANES*LANE_W-1:0] dq
);
    localparam int DW = LANES * LANE_W;

    zt_cmd_e           cmd;
    logic              act, wr;
    logic [ADDR_W-1:0] eff_addr;
    logic [DW-1:0]     rdata;
    logic              en, wr_commit, drive_en;

    assign en        = !ce_n;
    assign wr_commit = en && act && wr;
    assign drive_en  = act && !wr && !oe_n;

    zt_cmd_decode u_dec (
        .cs_a_n  (cs_a_n),
        .cs_b_n  (cs_b_n),
        .cs_c    (cs_c),
        .adv_ld_n(adv_ld_n),
        .cmd     (cmd)
    );

    zt_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cmd      (cmd),
        .addr     (addr),
        .we_n     (we_n),
        .lin_burst(lin_burst),
        .act_o    (act),
        .wr_o     (wr),
        .eff_addr (eff_addr)
    );

    zt_byte_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk    (clk),
        .wr_en  (wr_commit),
        .waddr  (eff_addr),
        .wdata  (dq),
        .wmask_n(bw_n),
        .raddr  (eff_addr),
        .rdata  (rdata)
    );

    assign dq = drive_en ? rdata : {DW{1'bz}};

    assert_bus_float_after_desel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cmd == CMD_DESEL) |=> !drive_en);

    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(act) && $stable(wr) && $stable(eff_addr)));
endmodule

// File: tb/test_zt_sram.sv
module test_zt_sram;
    localparam int AW = 8;
    localparam logic [35:0] ZZ = {36{1'bz}};

    logic clk = 0, rst_n = 0;
    logic [AW-1:0] addr = '0;
    logic cs_a_n = 1, cs_b_n = 0, cs_c = 1, adv_ld_n = 0, we_n = 1, ce_n = 0;
    logic [3:0] bw_n = 4'hf;
    logic lin_burst = 1, oe_n = 0;
    logic [35:0] tb_dq = '0;
    logic tb_drv = 0;
    wire  [35:0] dq;
    int n_chk = 0, n_bad = 0;
    logic [35:0] exp_mem [256];

    assign dq = tb_drv ? tb_dq : ZZ;

    always #10 clk = ~clk;

    zt_sram #(.ADDR_W(AW)) i_zt_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
        .cs_c(cs_c), .adv_ld_n(adv_ld_n), .we_n(we_n), .ce_n(ce_n), .bw_n(bw_n),
        .lin_burst(lin_burst), .oe_n(oe_n), .dq(dq)
    );

    task automatic chk(input string req, input logic [35:0] exp);
        n_chk++;
        if (dq !== exp) begin
            n_bad++;
            $display("FAIL %s: dq=%h expected %h", req, dq, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic load(input bit wr, input logic [AW-1:0] a);
        ce_n = 0; adv_ld_n = 0; cs_a_n = 0; cs_b_n = 0; cs_c = 1; we_n = !wr; addr = a;
    endtask

    task automatic adv;
        ce_n = 0; adv_ld_n = 1; addr = ~addr; we_n = ~we_n;
    endtask

    task automatic desel;
        ce_n = 0; adv_ld_n = 0; cs_a_n = 1;
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [35:0] d, input logic [3:0] m);
        tb_drv = 1; tb_dq = d; bw_n = m;
        for (int i = 0; i < 4; i++)
            if (!m[i]) exp_mem[a][9*i +: 9] = d[9*i +: 9];
    endtask

    function automatic logic [AW-1:0] beat(input logic [AW-1:0] b, input int k, input bit lin);
        logic [1:0] kk = 2'(k);
        return {b[AW-1:2], lin ? b[1:0] + kk : b[1:0] ^ kk};
    endfunction

    task automatic t_reset;
        chk("R3 reset float", ZZ);
    endtask

    task automatic t_single(input logic [AW-1:0] a, input logic [35:0] d);
        load(1, a); tick;
        put(a, d, 4'h0); desel; tick;
        tb_drv = 0; bw_n = 4'hf;
        load(0, a); tick;
        chk("R1 R4 R5 read after write", exp_mem[a]);
        desel; tick;
        chk("R3 float after deselect", ZZ);
    endtask

    task automatic t_mask(input logic [AW-1:0] a);
        load(1, a); tick;
        put(a, 36'hf_ffff_ffff, 4'b1010); desel; tick;
        tb_drv = 0; bw_n = 4'hf;
        load(0, a); tick;
        chk("R5 byte mask merge", exp_mem[a]);
        desel; tick;
    endtask

    task automatic t_read_mask(input logic [AW-1:0] a);
        load(0, a); bw_n = 4'h0; tick;
        chk("R6 read with masks low", exp_mem[a]);
        desel; tick;
        bw_n = 4'hf;
        load(0, a); tick;
        chk("R6 memory untouched", exp_mem[a]);
        desel; tick;
    endtask

    task automatic t_select(input logic [AW-1:0] a);
        for (int v = 0; v < 3; v++) begin
            load(0, a); tick;
            chk("R2 selected read", exp_mem[a]);
            adv_ld_n = 0;
            cs_a_n = (v == 0); cs_b_n = (v == 1); cs_c = (v != 2);
            tick;
            chk("R2 partial select deselects", ZZ);
        end
        adv; tick;
        chk("R2 advance after deselect idle", ZZ);
        desel; tick;
    endtask

    task automatic t_burst(input logic [AW-1:0] b);
        lin_burst = 1;
        load(1, b); tick;
        for (int k = 0; k < 4; k++) begin
            put(beat(b, k, 1), 36'h5_0000_0000 + 36'(k * 36'h1_1111) + 36'(b), 4'h0);
            if (k < 3) adv; else desel;
            tick;
        end
        tb_drv = 0; bw_n = 4'hf;
        for (int m = 1; m >= 0; m--) begin
            lin_burst = m[0];
            load(0, b); tick;
            for (int k = 0; k < 4; k++) begin
                chk(m == 1 ? "R8 linear burst read" : "R8 interleaved burst read",
                    exp_mem[beat(b, k, m[0])]);
                if (k < 3) adv; else desel;
                tick;
            end
            chk("R3 float after burst", ZZ);
        end
        lin_burst = 1;
    endtask

    task automatic t_freeze(input logic [AW-1:0] a);
        load(1, a); tick;
        put(a, 36'h1_2121_2121, 4'h0); ce_n = 1; addr = ~a; tick;
        put(a, 36'h3_4343_4343, 4'h0); desel; tick;
        tb_drv = 0; bw_n = 4'hf;
        load(0, a); tick;
        chk("R7 data from enabled edge stored", exp_mem[a]);
        ce_n = 1; adv_ld_n = 0; cs_a_n = 1; tick;
        chk("R7 output held while frozen", exp_mem[a]);
        tick;
        chk("R7 output held second frozen edge", exp_mem[a]);
        desel; tick;
    endtask

    task automatic t_oe(input logic [AW-1:0] a);
        load(0, a); tick;
        oe_n = 1; #1;
        chk("R9 oe high floats", ZZ);
        oe_n = 0; #1;
        chk("R9 oe low drives", exp_mem[a]);
        desel; tick;
    endtask

    task automatic t_b2b(input logic [AW-1:0] ra, input logic [AW-1:0] wa);
        load(0, ra); tick;
        chk("R10 first read", exp_mem[ra]);
        load(1, wa); tick;
        put(wa, 36'h9_8765_4321, 4'h0); load(0, wa); #1;
        chk("R10 no contention in write period", 36'h9_8765_4321);
        tick;
        tb_drv = 0; bw_n = 4'hf; #1;
        chk("R10 read sees new word", exp_mem[wa]);
        desel; tick;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = 'x;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        t_reset();
        tick;
        t_single(8'h10, 36'h1_2345_6789);
        t_mask(8'h10);
        t_read_mask(8'h10);
        t_select(8'h10);
        t_burst(8'h21);
        t_freeze(8'h40);
        t_oe(8'h40);
        t_b2b(8'h10, 8'h50);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule